// File: doc/BRIEF.md
# Dual-Polynomial Serial CRC Unit

This block computes a cyclic redundancy code one bit per clock. It can use either of two generator polynomials: a wide degree-16 code for data payloads or a narrow degree-5 code for short token fields. The polynomial is chosen when a message starts. In generate mode the block takes the message bits, most significant first. When the message ends it streams out the remainder bits that the sender appends to form the codeword. In check mode it takes a whole codeword and, when the codeword ends, reports whether the remainder of the division by the generator is zero.

A transfer begins with a one-cycle start pulse, which clears the remainder register and latches the polynomial choice and the mode. Bits are then presented with a qualifier, so the source may pause at any point. The last bit carries an end strobe. Either the remainder is shifted out under an output-valid flag or the result appears at once. A done flag then holds the outcome until the next start.

Top module: `serial_crc_unit`

## Requirements
- R1: After reset, busy, done and outValid are all low.
- R2: A start pulse (startIn high for one cycle) clears the remainder register and latches polySel (0 = degree-16 generator 0x18005, 1 = degree-5 generator 0x25) and checkMode (0 = generate, 1 = check). From the next cycle, busy is high and done and outValid are low.
- R3: In generate mode with polySel = 0, the 16 bits shifted out equal the remainder of the message times 2^16 divided modulo 2 by x^16 + x^15 + x^2 + 1.
- R4: In generate mode with polySel = 1, the 5 bits shifted out equal the remainder of the message times 2^5 divided by x^5 + x^2 + 1. For the 8-bit message 10100101 the remainder is 01110.
- R5: In generate mode, outValid is high for exactly n consecutive cycles (n = 16 or 5), starting the cycle after the end strobe is sampled. The remainder leaves on outBit most significant bit first. done rises in the cycle after the last bit and outValid is low from then on.
- R6: In check mode, done rises in the cycle after the end strobe is sampled. crcErr is low exactly when the codeword leaves a zero remainder, and high on any nonzero remainder.
- R7: Changes on polySel or checkMode after the start pulse do not affect the transfer in progress.
- R8: In degree-5 operation the upper 11 register bits stay zero, so a valid 5-bit codeword reports crcErr low.
- R9: Cycles with bitValid low inside a message add no bit. bitIn, bitValid and msgEnd have no effect while the block is not accepting bits.
- R10: done and crcErr hold their values until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse, clears and latches the configuration |
| polySel | input | 1 | 0 selects the degree-16 generator, 1 the degree-5 generator |
| checkMode | input | 1 | 0 generate, 1 check |
| bitValid | input | 1 | Qualifies bitIn |
| bitIn | input | 1 | Serial message or codeword bit, most significant first |
| msgEnd | input | 1 | Marks the final bit (or the end, if bitValid is low) |
| outValid | output | 1 | Remainder bit present on outBit |
| outBit | output | 1 | Serial remainder bit |
| busy | output | 1 | Accepting bits or shifting out |
| done | output | 1 | Transfer complete, result held |
| crcErr | output | 1 | Nonzero remainder (meaningful in check mode) |

## Verification
The assertions watch the handshake on every cycle:
- a start empties the pipeline and clears done;
- outValid only appears while busy, and never in a run longer than the wide degree;
- a falling outValid is followed by done unless a restart intervened;
- done and crcErr hold steady until the next start.

Whether the remainder values are right shows only in the bench's sweeps:
- every 8-bit message under the narrow code;
- a spread of 16-bit messages under the wide code;
- the valid and single-bit-corrupted codewords built from each of them;
- stalls and configuration changes in the middle of a message.

// File: rtl/crc_unit_pkg.sv
`timescale 1ns/1ps
package crc_unit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCEPT,
    ST_SHIFT,
    ST_DONE
  } crcState_t;

  // Strobes from the sequencer to the shift register
  typedef struct packed {
    logic clear;
    logic shiftIn;
    logic shiftOut;
    logic narrow;
  } crcStrobe_t;

endpackage

// File: rtl/crc_shift_dp.sv
`timescale 1ns/1ps
module crc_shift_dp
  import crc_unit_pkg::*;
#(
  parameter int unsigned WIDE_DEG = 16,
  parameter int unsigned NARROW_DEG = 5,
  parameter logic [WIDE_DEG-1:0] WIDE_POLY = 16'h8005,
  parameter logic [NARROW_DEG-1:0] NARROW_POLY = 5'h05
) (
  input  logic       clk,
  input  logic       rstN,
  input  crcStrobe_t strobe,
  input  logic       bitIn,
  output logic       msbOut,
  output logic       nonZero
);

  localparam logic [WIDE_DEG-1:0] NARROW_MASK = WIDE_DEG'((1 << NARROW_DEG) - 1);
  localparam logic [WIDE_DEG-1:0] NARROW_TAPS = WIDE_DEG'(NARROW_POLY);

  logic [WIDE_DEG-1:0] crcQ, crcD;
  logic [WIDE_DEG-1:0] mask, taps, shifted;
  logic                msb, feedback;

  always_comb begin
    msb      = strobe.narrow ? crcQ[NARROW_DEG-1] : crcQ[WIDE_DEG-1];
    mask     = strobe.narrow ? NARROW_MASK : '1;
    taps     = strobe.narrow ? NARROW_TAPS : WIDE_POLY;
    feedback = bitIn ^ msb;
    shifted  = {crcQ[WIDE_DEG-2:0], 1'b0};
    crcD     = crcQ;
    if (strobe.clear) begin
      crcD = '0;
    end else if (strobe.shiftIn) begin
      crcD = (shifted ^ (feedback ? taps : '0)) & mask;
    end else if (strobe.shiftOut) begin
      crcD = shifted & mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) crcQ <= '0;
    else       crcQ <= crcD;
  end

  assign msbOut  = msb;
  // whole register: any leak into the upper bits shows as an error
  assign nonZero = |crcQ;

endmodule

// File: rtl/crc_seq_ctrl.sv
`timescale 1ns/1ps
module crc_seq_ctrl
  import crc_unit_pkg::*;
#(
  parameter int unsigned WIDE_DEG = 16,
  parameter int unsigned NARROW_DEG = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       polySel,
  input  logic       checkMode,
  input  logic       bitValid,
  input  logic       msgEnd,
  output crcStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       outValid
);

  localparam int unsigned CNT_W = $clog2(WIDE_DEG + 1);

  crcState_t        stateQ;
  logic             narrowQ, checkQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      narrowQ <= 1'b0;
      checkQ  <= 1'b0;
      cntQ    <= '0;
    end else if (startIn) begin
      stateQ  <= ST_ACCEPT;
      narrowQ <= polySel;
      checkQ  <= checkMode;
      cntQ    <= '0;
    end else begin
      unique case (stateQ)
        ST_ACCEPT: begin
          if (msgEnd) begin
            if (checkQ) begin
              stateQ <= ST_DONE;
            end else begin
              stateQ <= ST_SHIFT;
              cntQ   <= narrowQ ? CNT_W'(NARROW_DEG) : CNT_W'(WIDE_DEG);
            end
          end
        end
        ST_SHIFT: begin
          cntQ <= cntQ - 1'b1;
          if (cntQ == CNT_W'(1)) stateQ <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.clear    = startIn;
    strobe.shiftIn  = (stateQ == ST_ACCEPT) && bitValid && !startIn;
    strobe.shiftOut = (stateQ == ST_SHIFT) && !startIn;
    strobe.narrow   = narrowQ;
  end

  assign busy     = (stateQ == ST_ACCEPT) || (stateQ == ST_SHIFT);
  assign done     = (stateQ == ST_DONE);
  assign outValid = (stateQ == ST_SHIFT);

endmodule

// File: rtl/serial_crc_unit.sv
`timescale 1ns/1ps
module serial_crc_unit
  import crc_unit_pkg::*;
#(
  parameter int unsigned WIDE_DEG = 16,
  parameter int unsigned NARROW_DEG = 5,
  parameter logic [WIDE_DEG-1:0] WIDE_POLY = 16'h8005,
  parameter logic [NARROW_DEG-1:0] NARROW_POLY = 5'h05
) (
  input  logic clk,
  input  logic rstN,
  input  logic startIn,
  input  logic polySel,
  input  logic checkMode,
  input  logic bitValid,
  input  logic bitIn,
  input  logic msgEnd,
  output logic outValid,
  output logic outBit,
  output logic busy,
  output logic done,
  output logic crcErr
);

  crcStrobe_t strobe;
  logic       msbOut, nonZero;

  crc_seq_ctrl #(
    .WIDE_DEG  (WIDE_DEG),
    .NARROW_DEG(NARROW_DEG)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .polySel  (polySel),
    .checkMode(checkMode),
    .bitValid (bitValid),
    .msgEnd   (msgEnd),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .outValid (outValid)
  );

  crc_shift_dp #(
    .WIDE_DEG   (WIDE_DEG),
    .NARROW_DEG (NARROW_DEG),
    .WIDE_POLY  (WIDE_POLY),
    .NARROW_POLY(NARROW_POLY)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .bitIn  (bitIn),
    .msbOut (msbOut),
    .nonZero(nonZero)
  );

  assign outBit = msbOut;
  assign crcErr = nonZero;

endmodule

// File: rtl/serial_crc_unit_chk.sv
`timescale 1ns/1ps
module serial_crc_unit_chk #(
  parameter int unsigned WIDE_DEG = 16
) (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic busy,
  input logic done,
  input logic outValid,
  input logic crcErr
);

  localparam int unsigned RUN_W = $clog2(WIDE_DEG + 2);

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)         runLen <= '0;
    else if (outValid) runLen <= runLen + 1'b1;
    else               runLen <= '0;
  end

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (busy && !done && !outValid));

  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= RUN_W'(WIDE_DEG));

  // R5
  shift_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(outValid) && !$past(startIn)) |-> done);

  // R9
  out_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startIn) |=> (done && $stable(crcErr)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !outValid));

endmodule

bind serial_crc_unit serial_crc_unit_chk #(.WIDE_DEG(WIDE_DEG)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .startIn (startIn),
  .busy    (busy),
  .done    (done),
  .outValid(outValid),
  .crcErr  (crcErr)
);

// File: tb/serial_crc_unit_bench.sv
`timescale 1ns/1ps
module serial_crc_unit_bench;

  logic clk = 1'b0;
  logic rstN, startIn, polySel, checkMode, bitValid, bitIn, msgEnd;
  logic outValid, outBit, busy, done, crcErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_crc_unit u_serial_crc_unit (
    .clk(clk), .rstN(rstN), .startIn(startIn), .polySel(polySel),
    .checkMode(checkMode), .bitValid(bitValid), .bitIn(bitIn), .msgEnd(msgEnd),
    .outValid(outValid), .outBit(outBit), .busy(busy), .done(done), .crcErr(crcErr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // modulo-2 long division of a bit string by the selected generator
  function automatic logic [15:0] polyMod(input bit narrow, input logic [31:0] bits, input int len);
    int n = narrow ? 5 : 16;
    logic [16:0] g = narrow ? 17'h00025 : 17'h18005;
    logic [16:0] r = '0;
    for (int i = len - 1; i >= 0; i--) begin
      r = {r[15:0], bits[i]};
      if (r[n]) r = r ^ g;
    end
    return r[15:0];
  endfunction

  task automatic sendBits(input logic [31:0] bits, input int len, input bit sel,
                          input bit chkMode, input int stallAt);
    @(negedge clk);
    startIn = 1; polySel = sel; checkMode = chkMode; bitValid = 0; msgEnd = 0;
    @(negedge clk);
    startIn = 0;
    chk(busy && !done && !outValid, "R2", {busy, done, outValid}, 3'b100);
    for (int i = len - 1; i >= 0; i--) begin
      if (i == stallAt) begin
        // R9 idle slot with junk data, R7 configuration flip
        bitValid = 0; bitIn = ~bits[i]; polySel = ~sel; checkMode = ~chkMode;
        @(negedge clk);
      end
      bitValid = 1; bitIn = bits[i]; msgEnd = (i == 0);
      @(negedge clk);
    end
    bitValid = 0; msgEnd = 0; polySel = ~sel; checkMode = ~chkMode;
  endtask

  task automatic genCase(input bit sel, input logic [15:0] msg, input int len,
                         input int stallAt, output logic [15:0] rem);
    int n = sel ? 5 : 16;
    logic [15:0] got = '0;
    logic [15:0] exp;
    bit framed = 1;
    sendBits({16'h0, msg}, len, sel, 1'b0, stallAt);
    for (int k = 0; k < n; k++) begin
      if (!outValid) framed = 0;
      got = {got[14:0], outBit};
      @(negedge clk);
    end
    exp = polyMod(sel, {16'h0, msg} << n, len + n);
    if (sel) chk(got == exp, "R4", got, exp);
    else     chk(got == exp, "R3", got, exp);
    chk(framed && done && !outValid, "R5", {framed, done, outValid}, 3'b110);
    rem = got;
  endtask

  task automatic checkCase(input bit sel, input logic [31:0] cw, input int len,
                           input int stallAt, input bit expErr, input string req);
    sendBits(cw, len, sel, 1'b1, stallAt);
    chk(done, "R6", done, 1);
    chk(crcErr == expErr, req, crcErr, expErr);
    // R9/R10: junk while done changes nothing
    bitValid = 1; bitIn = 1; msgEnd = 1;
    @(negedge clk);
    bitValid = 0; msgEnd = 0;
    chk(done && (crcErr == expErr) && !outValid, "R10", {done, crcErr}, {1'b1, expErr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rem;
    logic [31:0] cw;
    rstN = 0; startIn = 0; polySel = 0; checkMode = 0; bitValid = 0; bitIn = 0; msgEnd = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !done && !outValid, "R1", {busy, done, outValid}, 0);

    // R4 worked example: 10100101 -> codeword 1010010101110
    genCase(1'b1, 16'h00A5, 8, -1, rem);
    chk(rem[4:0] == 5'b01110, "R4", rem, 5'b01110);
    chk({8'hA5, rem[4:0]} == 13'b1010010101110, "R4", {8'hA5, rem[4:0]}, 13'b1010010101110);

    // narrow code: every 8-bit message, generate, check clean, check corrupted
    for (int m = 0; m < 256; m++) begin
      int stall = (m % 3 == 0) ? (m % 8) : -1;
      genCase(1'b1, 16'(m), 8, stall, rem);
      cw = {19'h0, 8'(m), rem[4:0]};
      checkCase(1'b1, cw, 13, stall, 1'b0, "R8");
      checkCase(1'b1, cw ^ (32'h1 << (m % 13)), 13, -1, 1'b1, "R6");
    end

    // wide code: spread of 16-bit messages
    for (int m = 0; m < 48; m++) begin
      logic [15:0] msg = (m == 0) ? 16'h0000 : (m == 1) ? 16'hFFFF : 16'(m * 40503 ^ (m << 7));
      int stall = (m % 2 == 0) ? (m % 16) : -1;
      genCase(1'b0, msg, 16, stall, rem);
      cw = {msg, rem};
      checkCase(1'b0, cw, 32, stall, 1'b0, "R6");
      checkCase(1'b0, cw ^ (32'h1 << (m % 32)), 32, -1, 1'b1, "R6");
    end

    // R2: restart in the middle of a shift-out starts clean
    sendBits(32'h0000_00FF, 8, 1'b0, 1'b0, -1);
    repeat (3) @(negedge clk);
    checkCase(1'b1, {19'h0, 8'hA5, 5'b01110}, 13, -1, 1'b0, "R2");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule